// File: doc/BRIEF.md
# Processor Clock-Stop and Sleep State Sequencer

This block tracks which clock-control state a processor core is in and moves it between states in response to platform request pins and core-side strobes. It covers seven operating states plus a PLL relock wait: running, halted after a halt instruction, clock-stop granted, a snoop sub-state entered from either the halted or the clock-stop state, sleep, deep sleep, and a deeper low-voltage sleep. Entry into clock-stop is delayed by a fixed number of bus clocks. Leaving deep sleep passes through a timed relock wait before the core counts as sleeping again.

While the clocks are stopped, wake events cannot be serviced. The block holds one pending flag per event class until the core runs again, and raises a break-request output so that system logic knows to restart the core. It also asserts a power-status output for the voltage regulator in the two deepest states. It raises sticky error flags when the platform asks for sleep in a state where that is not allowed, or releases the stop-clock request too soon after releasing sleep.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After block reset, `state_code` is 0 (running), `core_clk_en` is 1, and `psi`, `pending_break`, `evt_latched`, `slp_req_err` and `order_err` are all 0. State codes: 0 running, 1 halted, 2 clock-stop granted, 3 snoop, 4 sleep, 5 deep sleep, 6 deeper sleep, 7 PLL relock.
- R2: In running, a `halt_strobe` sampled high moves the state to halted. In halted, any set bit of `evt_in` returns the state to running. Bit positions: [0] management interrupt, [1] init, [2] local interrupt line, [3] bus interrupt message.
- R3: From running or halted, the state becomes clock-stop granted on the GRANT_DLY-th consecutive clock edge at which `stpclk_n` is sampled low. Releasing `stpclk_n` before that edge restarts the count from zero.
- R4: In clock-stop granted, `stpclk_n` sampled high returns the state to halted if the core was halted when it entered clock-stop, and to running otherwise.
- R5: `snoop_start` in halted or clock-stop granted moves the state to snoop. `snoop_done` in snoop returns the state to the parent state it came from.
- R6: In clock-stop granted and in snoop, each `evt_in` bit sampled high sets the matching `evt_latched` bit, and a repeated event leaves it set. The vector clears at the clock edge after the state is running. In halted, a nonzero `evt_latched` wakes the core like a live event.
- R7: `pending_break` is high exactly when the state is clock-stop granted and at least one `evt_latched` bit is set.
- R8: Sleep is entered only from clock-stop granted, when `slp_n` is sampled low. `slp_n` low in running, halted or snoop does not change the state, and it sets the sticky `slp_req_err`.
- R9: `dpslp_n` low in sleep enters deep sleep. In deep sleep, `lowv_req` high enters deeper sleep. In deeper sleep, `lowv_req` low returns to deep sleep.
- R10: `dpslp_n` high in deep or deeper sleep enters PLL relock. The state becomes sleep after RELOCK_CYC = CLK_MHZ*RELOCK_US clock edges in relock. `slp_n` high in sleep returns the state to clock-stop granted.
- R11: `psi` is high in deep sleep and deeper sleep, and low in every other state, including relock.
- R12: `core_reset` in clock-stop granted keeps the state there and clears `evt_latched` and the halted memory. In sleep, it moves the state straight to running. In running or halted, it moves the state to running.
- R13: `order_err` is set, and stays set until block reset, when `stpclk_n` rises fewer than MIN_GAP clock edges after `slp_n` rises. A rise on the same edge counts as a gap of zero.
- R14: `core_clk_en` is high only in running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stpclk_n | input | 1 | Stop-clock request, active low |
| slp_n | input | 1 | Sleep request, active low |
| dpslp_n | input | 1 | Deep-sleep request, active low |
| lowv_req | input | 1 | Low-voltage (deeper sleep) request |
| halt_strobe | input | 1 | Core executed a halt instruction |
| snoop_start | input | 1 | Bus snoop or interrupt transaction begins |
| snoop_done | input | 1 | Snoop serviced or interrupt latched |
| core_reset | input | 1 | Core reset event |
| evt_in | input | 4 | Wake events: [0] mgmt irq, [1] init, [2] local irq, [3] bus irq message |
| state_code | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| pending_break | output | 1 | Break request while clock-stop holds latched events |
| psi | output | 1 | Power-status indicator for deep states |
| evt_latched | output | 4 | Held events, same bit order as `evt_in` |
| slp_req_err | output | 1 | Sticky: sleep requested in an illegal state |
| order_err | output | 1 | Sticky: stop-clock released too soon after sleep release |

## Verification
Two things can fall on the same clock edge. Releasing the stop-clock request can coincide with the capture of a latched event, and a sleep release can coincide with a stop-clock release. The bench releases `stpclk_n` while `evt_latched` is populated and checks that the vector is still visible in the first running cycle and empty one cycle later. It then sweeps the gap between the `slp_n` rise and the `stpclk_n` rise from zero edges up past MIN_GAP. For each gap it computes whether `order_err` must be set, including the case where both rises land on the same edge.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_HALT   = 3'd1,
    PS_GRANT  = 3'd2,
    PS_SNOOP  = 3'd3,
    PS_SLEEP  = 3'd4,
    PS_DEEP   = 3'd5,
    PS_DEEPER = 3'd6,
    PS_RELOCK = 3'd7
  } pwr_state_e;

  localparam int EVT_W = 4;
endpackage

// File: rtl/pwr_dwell_counter.sv
module pwr_dwell_counter #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3 and R10: each running, unfinished cycle advances the count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r10_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwr_event_latch.sv
module pwr_event_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         clear,
  input  logic [W-1:0] evt_in,
  output logic [W-1:0] latched
);
  logic [W-1:0] lat_d;

  always_comb begin
    if (clear)        lat_d = '0;
    else if (capture) lat_d = latched | evt_in;
    else              lat_d = latched;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latched <= '0;
    else        latched <= lat_d;
  end

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clear) |=> (latched == $past(latched)));
  a_r6_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !clear) |=> ((latched & $past(evt_in)) == $past(evt_in)));
endmodule

// File: rtl/pwr_order_monitor.sv
module pwr_order_monitor #(
  parameter int MIN_GAP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slp_n,
  input  logic stpclk_n,
  output logic order_err
);
  localparam int GW = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(MIN_GAP - 1);

  logic          slp_q, stp_q, armed_q;
  logic [GW-1:0] gap_q;
  logic          slp_rise, stp_rise;

  assign slp_rise = slp_n & ~slp_q;
  assign stp_rise = stpclk_n & ~stp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_q     <= 1'b1;
      stp_q     <= 1'b1;
      armed_q   <= 1'b0;
      gap_q     <= '0;
      order_err <= 1'b0;
    end else begin
      slp_q <= slp_n;
      stp_q <= stpclk_n;
      if (slp_rise) begin
        armed_q <= !stp_rise;
        gap_q   <= '0;
        if (stp_rise) order_err <= 1'b1;
      end else if (armed_q) begin
        if (stp_rise && (gap_q < GAP_LAST)) order_err <= 1'b1;
        if (stp_rise || (gap_q == GAP_LAST)) armed_q <= 1'b0;
        else                                 gap_q   <= gap_q + 1'b1;
      end
    end
  end

  a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |=> order_err);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int GRANT_DLY = 20,
  parameter int CLK_MHZ   = 100,
  parameter int RELOCK_US = 30,
  parameter int MIN_GAP   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stpclk_n,
  input  logic             slp_n,
  input  logic             dpslp_n,
  input  logic             lowv_req,
  input  logic             halt_strobe,
  input  logic             snoop_start,
  input  logic             snoop_done,
  input  logic             core_reset,
  input  logic [EVT_W-1:0] evt_in,
  output logic [2:0]       state_code,
  output logic             core_clk_en,
  output logic             pending_break,
  output logic             psi,
  output logic [EVT_W-1:0] evt_latched,
  output logic             slp_req_err,
  output logic             order_err
);
  localparam int RELOCK_CYC = CLK_MHZ * RELOCK_US;

  pwr_state_e state_q, state_d;
  logic       halted_q, halted_d;
  logic       parent_grant_q, parent_grant_d;
  logic       slp_err_d;
  logic       grant_run, grant_done;
  logic       relock_run, relock_done;
  logic       wake, lat_capture, lat_clear;

  assign grant_run   = ((state_q == PS_RUN) || (state_q == PS_HALT)) && !stpclk_n;
  assign relock_run  = (state_q == PS_RELOCK);
  assign wake        = (|evt_in) || (|evt_latched);
  assign lat_capture = (state_q == PS_GRANT) || (state_q == PS_SNOOP);
  assign lat_clear   = (state_q == PS_RUN) || (core_reset && (state_q == PS_GRANT));

  pwr_dwell_counter #(.LIMIT(GRANT_DLY)) u_grant_dly (
    .clk(clk), .rst_n(rst_n), .run(grant_run), .done(grant_done));

  pwr_dwell_counter #(.LIMIT(RELOCK_CYC)) u_relock_dly (
    .clk(clk), .rst_n(rst_n), .run(relock_run), .done(relock_done));

  pwr_event_latch #(.W(EVT_W)) u_evt_latch (
    .clk(clk), .rst_n(rst_n), .capture(lat_capture), .clear(lat_clear),
    .evt_in(evt_in), .latched(evt_latched));

  pwr_order_monitor #(.MIN_GAP(MIN_GAP)) u_order_mon (
    .clk(clk), .rst_n(rst_n), .slp_n(slp_n), .stpclk_n(stpclk_n),
    .order_err(order_err));

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN: begin
        if (core_reset)       state_d = PS_RUN;
        else if (grant_done)  state_d = PS_GRANT;
        else if (halt_strobe) state_d = PS_HALT;
      end
      PS_HALT: begin
        if (core_reset)       state_d = PS_RUN;
        else if (grant_done)  state_d = PS_GRANT;
        else if (wake)        state_d = PS_RUN;
        else if (snoop_start) state_d = PS_SNOOP;
      end
      PS_GRANT: begin
        if (stpclk_n)         state_d = (halted_q && !core_reset) ? PS_HALT : PS_RUN;
        else if (!slp_n)      state_d = PS_SLEEP;
        else if (snoop_start) state_d = PS_SNOOP;
      end
      PS_SNOOP: begin
        if (snoop_done)       state_d = parent_grant_q ? PS_GRANT : PS_HALT;
      end
      PS_SLEEP: begin
        if (core_reset)       state_d = PS_RUN;
        else if (slp_n)       state_d = PS_GRANT;
        else if (!dpslp_n)    state_d = PS_DEEP;
      end
      PS_DEEP: begin
        if (dpslp_n)          state_d = PS_RELOCK;
        else if (lowv_req)    state_d = PS_DEEPER;
      end
      PS_DEEPER: begin
        if (dpslp_n)          state_d = PS_RELOCK;
        else if (!lowv_req)   state_d = PS_DEEP;
      end
      PS_RELOCK: begin
        if (relock_done)      state_d = PS_SLEEP;
      end
      default:                state_d = PS_RUN;
    endcase
  end

  always_comb begin
    halted_d = halted_q;
    if (core_reset && (state_q == PS_RUN || state_q == PS_HALT ||
                       state_q == PS_GRANT || state_q == PS_SLEEP))
      halted_d = 1'b0;
    else if (state_q == PS_HALT)
      halted_d = 1'b1;
    else if (state_q == PS_RUN)
      halted_d = 1'b0;

    parent_grant_d = (state_q == PS_SNOOP) ? parent_grant_q : (state_q == PS_GRANT);

    slp_err_d = slp_req_err ||
                (!slp_n && (state_q == PS_RUN || state_q == PS_HALT || state_q == PS_SNOOP));
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= PS_RUN;
      halted_q       <= 1'b0;
      parent_grant_q <= 1'b0;
      slp_req_err    <= 1'b0;
    end else begin
      state_q        <= state_d;
      halted_q       <= halted_d;
      parent_grant_q <= parent_grant_d;
      slp_req_err    <= slp_err_d;
    end
  end

  assign state_code    = state_q;
  assign core_clk_en   = (state_q == PS_RUN);
  assign psi           = (state_q == PS_DEEP) || (state_q == PS_DEEPER);
  assign pending_break = (state_q == PS_GRANT) && (|evt_latched);

  a_r3_grant_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_GRANT) && ($past(state_q) == PS_RUN || $past(state_q) == PS_HALT))
      |-> !$past(stpclk_n));
  a_r8_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_SLEEP) && ($past(state_q) != PS_SLEEP))
      |-> ($past(state_q) == PS_GRANT || $past(state_q) == PS_RELOCK));
  a_r11_psi_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psi) |-> ($past(state_q) == PS_SLEEP));
  a_r5_snoop_return: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_SNOOP) && snoop_done) |=> (state_q == PS_GRANT || state_q == PS_HALT));
  a_r12_grant_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_GRANT) && core_reset && !stpclk_n && slp_n && !snoop_start)
      |=> ((state_q == PS_GRANT) && (evt_latched == '0)));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    slp_req_err |=> slp_req_err);
endmodule

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int GD  = 4;
  localparam int MHZ = 2;
  localparam int US  = 3;
  localparam int RC  = MHZ * US;
  localparam int MG  = 10;

  logic       clk = 1'b0;
  logic       rst_n, stpclk_n, slp_n, dpslp_n, lowv_req;
  logic       halt_strobe, snoop_start, snoop_done, core_reset;
  logic [3:0] evt_in;
  logic [2:0] state_code;
  logic       core_clk_en, pending_break, psi, slp_req_err, order_err;
  logic [3:0] evt_latched;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctrl #(.GRANT_DLY(GD), .CLK_MHZ(MHZ), .RELOCK_US(US), .MIN_GAP(MG)) uut (
    .clk(clk), .rst_n(rst_n), .stpclk_n(stpclk_n), .slp_n(slp_n), .dpslp_n(dpslp_n),
    .lowv_req(lowv_req), .halt_strobe(halt_strobe), .snoop_start(snoop_start),
    .snoop_done(snoop_done), .core_reset(core_reset), .evt_in(evt_in),
    .state_code(state_code), .core_clk_en(core_clk_en), .pending_break(pending_break),
    .psi(psi), .evt_latched(evt_latched), .slp_req_err(slp_req_err), .order_err(order_err));

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    stpclk_n = 1'b1; slp_n = 1'b1; dpslp_n = 1'b1; lowv_req = 1'b0;
    halt_strobe = 1'b0; snoop_start = 1'b0; snoop_done = 1'b0; core_reset = 1'b0;
    evt_in = 4'h0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic pulse_evt(input logic [3:0] bits);
    evt_in = bits; tick(1); evt_in = 4'h0;
  endtask

  task automatic do_halt();
    halt_strobe = 1'b1; tick(1); halt_strobe = 1'b0;
  endtask

  task automatic enter_grant();
    stpclk_n = 1'b0; tick(GD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 and R14: reset values
    chk("R1 state", state_code, 0);
    chk("R14 clk_en", core_clk_en, 1);
    chk("R1 psi", psi, 0);
    chk("R1 evt", evt_latched, 0);
    chk("R1 pend", pending_break, 0);
    chk("R1 errs", {slp_req_err, order_err}, 0);

    // R2: halt and wake on each event bit
    for (int b = 0; b < 4; b++) begin
      do_halt();
      chk("R2 halted", state_code, 1);
      chk("R14 clk_en off", core_clk_en, 0);
      pulse_evt(4'(1 << b));
      chk("R2 wake", state_code, 0);
    end

    // R3: early release restarts the count
    for (int k = 1; k < GD; k++) begin
      stpclk_n = 1'b0; tick(k);
      chk("R3 not yet", state_code, 0);
      stpclk_n = 1'b1; tick(1);
      chk("R3 cancelled", state_code, 0);
    end
    stpclk_n = 1'b0; tick(GD - 1);
    chk("R3 edge-1", state_code, 0);
    tick(1);
    chk("R3 granted", state_code, 2);

    // R6, R7: latching while clock is stopped
    pulse_evt(4'b0100);
    chk("R6 lint", evt_latched, 4);
    chk("R7 pend", pending_break, 1);
    pulse_evt(4'b0100);
    chk("R6 once", evt_latched, 4);
    pulse_evt(4'b0001);
    chk("R6 smi", evt_latched, 5);
    // R4 release, same edge as latch hold
    stpclk_n = 1'b1; tick(1);
    chk("R4 to run", state_code, 0);
    chk("R6 visible", evt_latched, 5);
    chk("R7 pend off", pending_break, 0);
    tick(1);
    chk("R6 cleared", evt_latched, 0);

    // R4: return to halted
    do_halt();
    enter_grant();
    chk("R4 granted", state_code, 2);
    stpclk_n = 1'b1; tick(1);
    chk("R4 to halt", state_code, 1);
    tick(2);
    chk("R2 stays halted", state_code, 1);

    // R5: snoop from halted
    snoop_start = 1'b1; tick(1); snoop_start = 1'b0;
    chk("R5 snoop", state_code, 3);
    snoop_done = 1'b1; tick(1); snoop_done = 1'b0;
    chk("R5 back halt", state_code, 1);
    pulse_evt(4'b1000);
    chk("R2 bus msg", state_code, 0);

    // R5, R6: snoop from grant with event inside
    enter_grant();
    snoop_start = 1'b1; tick(1); snoop_start = 1'b0;
    chk("R5 snoop2", state_code, 3);
    pulse_evt(4'b0010);
    chk("R6 in snoop", evt_latched, 2);
    snoop_done = 1'b1; tick(1); snoop_done = 1'b0;
    chk("R5 back grant", state_code, 2);
    chk("R7 pend2", pending_break, 1);

    // R12: reset inside grant
    core_reset = 1'b1; tick(1); core_reset = 1'b0;
    chk("R12 stay grant", state_code, 2);
    chk("R12 evt clear", evt_latched, 0);

    // R8..R11: sleep ladder
    slp_n = 1'b0; tick(1);
    chk("R8 sleep", state_code, 4);
    chk("R14 off sleep", core_clk_en, 0);
    dpslp_n = 1'b0; tick(1);
    chk("R9 deep", state_code, 5);
    chk("R11 psi deep", psi, 1);
    lowv_req = 1'b1; tick(1);
    chk("R9 deeper", state_code, 6);
    chk("R11 psi deeper", psi, 1);
    lowv_req = 1'b0; tick(1);
    chk("R9 back deep", state_code, 5);
    lowv_req = 1'b1; tick(1);
    dpslp_n = 1'b1; tick(1);
    lowv_req = 1'b0;
    chk("R10 relock", state_code, 7);
    chk("R11 psi relock", psi, 0);
    tick(RC - 1);
    chk("R10 still relock", state_code, 7);
    tick(1);
    chk("R10 sleep", state_code, 4);
    slp_n = 1'b1; tick(1);
    chk("R10 to grant", state_code, 2);
    tick(MG);
    stpclk_n = 1'b1; tick(1);
    chk("R4 run", state_code, 0);
    chk("R13 no err", order_err, 0);

    // R12: halted memory dropped by reset in grant
    do_halt();
    enter_grant();
    core_reset = 1'b1; tick(1); core_reset = 1'b0;
    stpclk_n = 1'b1; tick(1);
    chk("R12 halt cleared", state_code, 0);

    // R12: reset in sleep
    enter_grant();
    slp_n = 1'b0; tick(1);
    core_reset = 1'b1; slp_n = 1'b1; stpclk_n = 1'b1; tick(1); core_reset = 1'b0;
    chk("R12 sleep reset", state_code, 0);
    chk("R8 no err", slp_req_err, 0);

    // R8: illegal sleep request
    slp_n = 1'b0; tick(1);
    chk("R8 ignored", state_code, 0);
    chk("R8 err", slp_req_err, 1);
    slp_n = 1'b1; tick(2);
    chk("R8 sticky", slp_req_err, 1);

    // R13: gap sweep
    for (int k = 0; k <= MG + 2; k++) begin
      do_reset();
      enter_grant();
      slp_n = 1'b0; tick(1);
      chk("R13 sleep", state_code, 4);
      slp_n = 1'b1;
      if (k == 0) stpclk_n = 1'b1;
      else begin
        tick(k);
        stpclk_n = 1'b1;
      end
      tick(1);
      chk("R13 gap", order_err, (k < MG) ? 1 : 0);
      tick(3);
      chk("R13 held", order_err, (k < MG) ? 1 : 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule